// File: doc/BRIEF.md
# Daisy-Chainable Serial DAC Front End

This block is the digital front end of a serial 16-bit converter. It receives a serial word, holds it in an input shift register, and passes it to a parallel DAC code register when a load is requested. The block samples every pin on one system clock. Four strobe pins merge into one shift clock. Three of them act on a rising edge and one acts on a falling edge. A strobe edge counts only while the other three strobes sit at their idle levels. Each counted edge moves one bit into the input register, most significant bit first.

The bit that leaves the top of the input register drives a serial output. Several devices can therefore be chained on one three-wire bus: a word sent into the first device comes out of its serial output 16 strobes later, ready for the next device. The parallel code updates while both active-low load pins are low. A one-cycle flag marks the start of each update. An asynchronous clear pin returns both registers to a reset code, and so does the power-on reset. A parameter sets the reset code to zero scale or to midscale.

To get single-clock operation, tie the three unused strobes idle and tie one load pin low.

Top module: `serial_dac_front`

## Requirements
- R1: After power-on reset the DAC code and the input register hold the reset code. This code is 0x0000 when CLR_MODE is CLR_ZERO and 0x8000 when CLR_MODE is CLR_MID. The serial output shows bit 15 of the reset code.
- R2: Each rising edge on stb_rise_a_i, stb_rise_b_i or stb_rise_d_i shifts the input register left by one place and puts sdi_i into bit 0. After 16 such edges the register holds the sent word, with the first bit sent in bit 15.
- R3: A falling edge on stb_fall_c_i shifts one bit in exactly like a rising edge on the other strobes.
- R4: While any rising-edge strobe is held high, or stb_fall_c_i is held low, edges on the other strobes shift nothing.
- R5: sdo_o equals bit 15 of the input register. It carries the previous word, MSB first, while a new word is shifted in, and it changes only on a counted strobe edge.
- R6: The DAC code loads from the input register only while ld_a_ni and ld_b_ni are both low. With either pin high the code holds.
- R7: While both load pins stay low, the DAC code follows the input register on every system clock, including bits shifted in during the load.
- R8: dac_updated_o is high for exactly one clock at the start of each load. It stays low when only one load pin is low.
- R9: Pulling clr_ni low resets the input register and the DAC code to the reset code at once, whatever the strobe and load pins are doing.
- R10: A load requested in the same cycle as the strobe edge of the last bit captures the complete new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all pins |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| clr_ni | input | 1 | Active-low asynchronous clear of both registers |
| stb_rise_a_i | input | 1 | Rising-edge strobe, idle low |
| stb_rise_b_i | input | 1 | Rising-edge strobe, idle low |
| stb_fall_c_i | input | 1 | Falling-edge strobe, idle high |
| stb_rise_d_i | input | 1 | Rising-edge strobe, idle low |
| sdi_i | input | 1 | Serial data in, MSB first |
| ld_a_ni | input | 1 | Active-low load pin A |
| ld_b_ni | input | 1 | Active-low load pin B |
| dac_code_o | output | DATA_W | Parallel DAC code |
| sdo_o | output | 1 | Serial data out for daisy-chaining |
| dac_updated_o | output | 1 | One-cycle flag at the start of each load |

## Verification
The bench builds two copies of the block side by side on the same pins, one with CLR_MODE set to CLR_MID and one with CLR_ZERO. Both use DATA_W of 16 and two synchronizer stages. Every shift and load therefore has to agree across both copies, while power-on and clear have to produce 0x8000 on one copy and 0x0000 on the other. Because the bench drives the same pins into both copies, it can check both reset codes against a single stream of serial traffic.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

  typedef enum logic {
    CLR_ZERO = 1'b0,
    CLR_MID  = 1'b1
  } clr_mode_e;

  typedef struct packed {
    logic rise_a;
    logic rise_b;
    logic fall_c;
    logic rise_d;
  } strobe_pins_t;

endpackage

// File: rtl/dac_sync_bit.sv
module dac_sync_bit #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/dac_strobe_gate.sv
module dac_strobe_gate
  import dac_fe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  strobe_pins_t strobes_i,
  input  logic         sdi_i,
  output logic         shift_en_o,
  output logic         sdi_o
);

  // any strobe leaving idle raises the merged strobe; others idle => edge counts
  logic merged;
  logic merged_s;
  logic merged_prev_q;

  assign merged = strobes_i.rise_a | strobes_i.rise_b | ~strobes_i.fall_c | strobes_i.rise_d;

  dac_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_stb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (merged),
    .q_o   (merged_s)
  );

  // data delayed by the same depth so it lines up with its strobe
  dac_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sdi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sdi_i),
    .q_o   (sdi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) merged_prev_q <= 1'b0;
    else         merged_prev_q <= merged_s;
  end

  assign shift_en_o = merged_s & ~merged_prev_q;

  AST_EN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o |=> !shift_en_o); // R2

endmodule

// File: rtl/dac_shift_reg.sv
module dac_shift_reg #(
  parameter int unsigned       DATA_W   = 16,
  parameter logic [DATA_W-1:0] RST_CODE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] word_o,
  output logic              sdo_o
);

  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_q <= RST_CODE;
    else if (shift_en_i) word_q <= {word_q[DATA_W-2:0], sdi_i};
  end

  assign word_o = word_q;
  assign sdo_o  = word_q[DATA_W-1];

  AST_SHIFT_BODY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> word_o[DATA_W-1:1] == $past(word_o[DATA_W-2:0])); // R2
  AST_SHIFT_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> word_o[0] == $past(sdi_i)); // R2
  AST_SDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(sdo_o)); // R5

endmodule

// File: rtl/dac_hold_reg.sv
module dac_hold_reg #(
  parameter int unsigned       DATA_W   = 16,
  parameter logic [DATA_W-1:0] RST_CODE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] code_o,
  output logic              updated_o
);

  logic [DATA_W-1:0] code_q;
  logic              load_prev_q;
  logic              updated_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q      <= RST_CODE;
      load_prev_q <= 1'b0;
      updated_q   <= 1'b0;
    end else begin
      load_prev_q <= load_i;
      updated_q   <= load_i & ~load_prev_q;
      if (load_i) code_q <= word_i;
    end
  end

  assign code_o    = code_q;
  assign updated_o = updated_q;

  AST_HOLD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(code_o)); // R6
  AST_FOLLOW_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> code_o == $past(word_i)); // R7
  AST_UPD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    updated_o |=> !updated_o); // R8
  AST_UPD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    updated_o |-> $past(load_i)); // R8

endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front
  import dac_fe_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter clr_mode_e   CLR_MODE    = CLR_ZERO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              stb_rise_a_i,
  input  logic              stb_rise_b_i,
  input  logic              stb_fall_c_i,
  input  logic              stb_rise_d_i,
  input  logic              sdi_i,
  input  logic              ld_a_ni,
  input  logic              ld_b_ni,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              sdo_o,
  output logic              dac_updated_o
);

  localparam logic [DATA_W-1:0] RST_CODE =
    (CLR_MODE == CLR_MID) ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  // clear touches data registers only; synchronizers keep their history
  logic data_rst_n;
  assign data_rst_n = rst_ni & clr_ni;

  strobe_pins_t      strobes;
  logic              shift_en;
  logic              sdi_s;
  logic              load_s;
  logic [DATA_W-1:0] in_word;

  assign strobes = '{rise_a: stb_rise_a_i, rise_b: stb_rise_b_i,
                     fall_c: stb_fall_c_i, rise_d: stb_rise_d_i};

  dac_strobe_gate #(.SYNC_STAGES(SYNC_STAGES)) i_strobe_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobes_i (strobes),
    .sdi_i     (sdi_i),
    .shift_en_o(shift_en),
    .sdi_o     (sdi_s)
  );

  // same depth as the strobe path keeps load ordered after the last shift
  dac_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_load (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (~ld_a_ni & ~ld_b_ni),
    .q_o   (load_s)
  );

  dac_shift_reg #(.DATA_W(DATA_W), .RST_CODE(RST_CODE)) i_shift_reg (
    .clk_i     (clk_i),
    .rst_ni    (data_rst_n),
    .shift_en_i(shift_en),
    .sdi_i     (sdi_s),
    .word_o    (in_word),
    .sdo_o     (sdo_o)
  );

  dac_hold_reg #(.DATA_W(DATA_W), .RST_CODE(RST_CODE)) i_hold_reg (
    .clk_i    (clk_i),
    .rst_ni   (data_rst_n),
    .load_i   (load_s),
    .word_i   (in_word),
    .code_o   (dac_code_o),
    .updated_o(dac_updated_o)
  );

  AST_CLR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (dac_code_o == RST_CODE) && (sdo_o == RST_CODE[DATA_W-1])); // R9

endmodule

// File: tb/test_serial_dac_front.sv
`timescale 1ns/100ps
module test_serial_dac_front;
  import dac_fe_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1;
  logic rise_a = 1'b0, rise_b = 1'b0, fall_c = 1'b1, rise_d = 1'b0;
  logic sdi = 1'b0;
  logic ld_a_n = 1'b1, ld_b_n = 1'b1;
  logic [15:0] code_mid, code_zero;
  logic sdo_mid, sdo_zero, upd_mid, upd_zero;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  serial_dac_front #(.DATA_W(16), .SYNC_STAGES(2), .CLR_MODE(CLR_MID)) i_serial_dac_front (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n),
    .stb_rise_a_i(rise_a), .stb_rise_b_i(rise_b), .stb_fall_c_i(fall_c), .stb_rise_d_i(rise_d),
    .sdi_i(sdi), .ld_a_ni(ld_a_n), .ld_b_ni(ld_b_n),
    .dac_code_o(code_mid), .sdo_o(sdo_mid), .dac_updated_o(upd_mid)
  );

  serial_dac_front #(.DATA_W(16), .SYNC_STAGES(2), .CLR_MODE(CLR_ZERO)) i_serial_dac_front_zero (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n),
    .stb_rise_a_i(rise_a), .stb_rise_b_i(rise_b), .stb_fall_c_i(fall_c), .stb_rise_d_i(rise_d),
    .sdi_i(sdi), .ld_a_ni(ld_a_n), .ld_b_ni(ld_b_n),
    .dac_code_o(code_zero), .sdo_o(sdo_zero), .dac_updated_o(upd_zero)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_strobe(input int which, input logic active);
    case (which)
      0: rise_a = active;
      1: rise_b = active;
      2: fall_c = ~active;
      default: rise_d = active;
    endcase
  endtask

  task automatic strobe_bit(input logic b, input int which);
    sdi = b;
    cyc(1);
    set_strobe(which, 1'b1);
    cyc(3);
    set_strobe(which, 1'b0);
    cyc(3);
  endtask

  task automatic send_word(input logic [15:0] w, input int which,
                           input bit chk_sdo, input logic [15:0] prev);
    for (int i = 15; i >= 0; i--) begin
      if (chk_sdo) chk("R5 sdo previous word", {15'd0, sdo_mid}, {15'd0, prev[i]});
      strobe_bit(w[i], which);
    end
  endtask

  task automatic count_pulses(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (upd_mid) pulses++;
    end
  endtask

  task automatic do_load(output int pulses);
    ld_a_n = 1'b0;
    ld_b_n = 1'b0;
    count_pulses(6, pulses);
    ld_a_n = 1'b1;
    ld_b_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_reset();
    chk("R1 mid reset code", code_mid, 16'h8000);
    chk("R1 zero reset code", code_zero, 16'h0000);
    chk("R1 mid sdo", {15'd0, sdo_mid}, 16'd1);
    chk("R1 zero sdo", {15'd0, sdo_zero}, 16'd0);
  endtask

  task automatic t_basic_shift();
    int p;
    send_word(16'h1234, 0, 1'b0, 16'h0);
    chk("R6 no load yet", code_mid, 16'h8000);
    do_load(p);
    chk("R2 rise_a word mid", code_mid, 16'h1234);
    chk("R2 rise_a word zero", code_zero, 16'h1234);
    chk("R8 one pulse per load", p[15:0], 16'd1);
  endtask

  task automatic t_fall_strobe();
    int p;
    send_word(16'hBEEF, 2, 1'b1, 16'h1234);
    chk("R5 sdo after word", {15'd0, sdo_mid}, 16'd1);
    do_load(p);
    chk("R3 falling strobe word", code_mid, 16'hBEEF);
  endtask

  task automatic t_mixed_strobe();
    int p;
    for (int i = 15; i >= 0; i--) strobe_bit(16'h0F0F >> i, (i % 2 == 0) ? 1 : 3);
    do_load(p);
    chk("R2 mixed strobes b/d", code_mid, 16'h0F0F);
  endtask

  task automatic t_blocking();
    int p;
    // raising the blocker is itself one edge: shifts a 0
    sdi = 1'b0;
    cyc(1);
    rise_b = 1'b1;
    cyc(4);
    sdi = 1'b1;
    for (int k = 0; k < 3; k++) begin
      strobe_bit(1'b1, 0);
      strobe_bit(1'b1, 2);
      strobe_bit(1'b1, 3);
    end
    rise_b = 1'b0;
    cyc(4);
    do_load(p);
    chk("R4 blocked strobes shift nothing", code_mid, 16'h1E1E);
  endtask

  task automatic t_load_gating();
    int p;
    send_word(16'h5555, 0, 1'b0, 16'h0);
    ld_a_n = 1'b0;
    count_pulses(6, p);
    chk("R6 only ld_a low holds", code_mid, 16'h1E1E);
    chk("R8 no pulse ld_a only", p[15:0], 16'd0);
    ld_a_n = 1'b1;
    ld_b_n = 1'b0;
    count_pulses(6, p);
    chk("R6 only ld_b low holds", code_mid, 16'h1E1E);
    chk("R8 no pulse ld_b only", p[15:0], 16'd0);
    ld_b_n = 1'b1;
    cyc(4);
    do_load(p);
    chk("R6 both low loads", code_mid, 16'h5555);
  endtask

  task automatic t_follow();
    ld_a_n = 1'b0;
    ld_b_n = 1'b0;
    cyc(4);
    strobe_bit(1'b1, 1);
    chk("R7 code follows during load", code_mid, 16'hAAAB);
    ld_a_n = 1'b1;
    ld_b_n = 1'b1;
    cyc(4);
    chk("R7 code kept after load", code_mid, 16'hAAAB);
  endtask

  task automatic t_zero_delay_load();
    for (int i = 15; i >= 1; i--) strobe_bit(16'h7E81 >> i, 0);
    sdi = 1'b1;
    cyc(1);
    rise_a = 1'b1;
    ld_a_n = 1'b0;
    ld_b_n = 1'b0;
    cyc(3);
    rise_a = 1'b0;
    ld_a_n = 1'b1;
    ld_b_n = 1'b1;
    cyc(4);
    chk("R10 load with last edge", code_mid, 16'h7E81);
  endtask

  task automatic t_clear();
    rise_a = 1'b1;
    ld_a_n = 1'b0;
    ld_b_n = 1'b0;
    cyc(4);
    #0.5 clr_n = 1'b0;
    #0.5;
    chk("R9 clear mid immediate", code_mid, 16'h8000);
    chk("R9 clear zero immediate", code_zero, 16'h0000);
    chk("R9 clear sdo mid", {15'd0, sdo_mid}, 16'd1);
    cyc(2);
    rise_a = 1'b0;
    ld_a_n = 1'b1;
    ld_b_n = 1'b1;
    cyc(4);
    clr_n = 1'b1;
    cyc(4);
    chk("R9 mid after clear release", code_mid, 16'h8000);
    chk("R9 zero after clear release", code_zero, 16'h0000);
  endtask

  task automatic run_all();
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_basic_shift();
    t_fall_strobe();
    t_mixed_strobe();
    t_blocking();
    t_load_gating();
    t_follow();
    t_zero_delay_load();
    t_clear();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule